// File: doc/BRIEF.md
# DMA Channel Control and Status Register Block

This block is the software-facing register file of a descriptor-driven DMA engine. A 32-bit register bus reaches one 0x100-byte window per channel. Each window holds a control/status word, the address of the current descriptor, the address of the next descriptor and an error-code register. It also gives read-only views of the descriptor fields that the channel sequencer has loaded. A shared window at the top of the address space holds a channel-enable mask and a per-channel interrupt summary.

A control/status write can carry several commands at once. A 1 in bit 0 starts or resumes the channel, and a 0 there pauses it. Writing 1 to the completion flags clears them. The abort bit drops the current descriptor, and the reset bit wipes the channel. The block turns these writes into one-cycle start and abort pulses and a run level for the sequencer. The sequencer reports completion, errors, pause confirmation and request/hold/wait state back, and these appear as status bits. Each channel drives one interrupt line. Data movement and descriptor fetch sit behind this handshake and are not part of the block.

Top module: `dma_chan_csr`

## Requirements
- R1: Channel n is addressed at n*0x100 plus a word offset. 0x00 is control/status, 0x04 the current descriptor address (read/write), 0x08 info, 0x0C source, 0x10 destination, 0x14 length, 0x18 stride, 0x1C the next descriptor address (read/write) and 0x20 the error register.
- R2: Writing control/status with bit 0 set, while the channel is idle and its enable bit is 1, sets ACTIVE (bit 0) and the run output. It also gives a one-cycle start pulse in the cycle after the write, with the descriptor-address output holding the current descriptor address.
- R3: A start write to a channel whose bit in the enable mask is 0 has no effect: ACTIVE stays 0 and no start pulse appears.
- R4: Writing control/status with bit 0 clear lowers ACTIVE and run, which pauses the sequencer. The sequencer inputs appear live in control/status: paused at bit 4, held at bit 5, waiting at bit 6 and request at bit 3.
- R5: A completion pulse from the sequencer sets END (bit 1). It also sets INT (bit 2) when bit 0 of the loaded info field is 1. Writing 1 to bit 1 or bit 2 clears that flag, and writing 0 there leaves it unchanged. The channel interrupt output is high while INT or ERROR is set.
- R6: On completion of an active channel, a nonzero next address is copied into the current descriptor address, ACTIVE stays 1 and a start pulse follows. If the next address is zero, ACTIVE drops to 0.
- R7: A control/status write with bit 30 set gives a one-cycle abort pulse, and the ACTIVE value in the same write is ignored. An active channel with a nonzero next address moves to that address with a start pulse. Otherwise ACTIVE becomes 0.
- R8: An error report from the sequencer ORs a code into bits 2:0 of the error register. Writing 1 to a code bit clears it. ERROR (control/status bit 8) reads 1 whenever the code is nonzero.
- R9: A control/status write with bit 31 set clears every register of that channel, including the stored bits 28 and 29, and gives an abort pulse. Bit 31 reads back as 0, and other channels are untouched.
- R10: Info, source, destination, length and stride read the values loaded by the sequencer and ignore software writes. The load field codes are 0 info, 1 source, 2 destination, 3 length, 4 stride and 5 next.
- R11: Address 0xFF0 is a read/write enable mask with bit n for channel n, reset to 0. Address 0xFE0 reads the interrupt line of channel n at bit n and ignores writes.
- R12: When a completion pulse arrives in the same cycle as a write that clears END and INT, the flags that the completion sets end up set.
- R13: Read data appears on the cycle after the read strobe and is 0 in any other cycle. Unmapped offsets and windows of channels that do not exist read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| ld_valid | input | 1 | Sequencer loads a descriptor field |
| ld_ch | input | ADDR_W-8 | Channel of the load |
| ld_field | input | 3 | Field code of the load |
| ld_data | input | 32 | Loaded value |
| sq_paused | input | NUM_CH | Sequencer confirms pause |
| sq_held | input | NUM_CH | Sequencer is held |
| sq_waiting | input | NUM_CH | Sequencer waits for outstanding writes |
| sq_dreq | input | NUM_CH | Peripheral request level seen by the channel |
| sq_done | input | NUM_CH | Descriptor completed (pulse) |
| sq_err_set | input | NUM_CH x 3 | Error code bits to set (pulse) |
| ch_run | output | NUM_CH | Channel run level |
| ch_go | output | NUM_CH | Start or resume pulse |
| ch_abort | output | NUM_CH | Abort pulse |
| ch_desc_addr | output | NUM_CH x 32 | Current descriptor address |
| ch_irq | output | NUM_CH | Channel interrupt line |

## Verification
The bench targets commands that meet in one write or one cycle. An abort carrying a 1 in the start bit must not restart a channel with an empty next address, or a driver's stop sequence would leave it running. A completion in the same cycle as a flag-clear write must not be lost, or an interrupt goes missing. A start on a masked channel, writes to the loaded-only fields and writes to the interrupt summary are checked at the read port and the run outputs; a design that let them through would show a changed value there. The channel reset is checked for clearing every field, the stored upper control bits included, while a neighbouring channel keeps its values. The descriptor chaining paths are checked for moving to the next address only when that address is nonzero.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
    localparam int DATA_W = 32;
    localparam int ERR_W  = 3;
    localparam int IDX_W  = 4;

    // word indices inside a channel window
    localparam logic [IDX_W-1:0] W_CS     = 4'd0;
    localparam logic [IDX_W-1:0] W_DESC   = 4'd1;
    localparam logic [IDX_W-1:0] W_INFO   = 4'd2;
    localparam logic [IDX_W-1:0] W_SRC    = 4'd3;
    localparam logic [IDX_W-1:0] W_DST    = 4'd4;
    localparam logic [IDX_W-1:0] W_LEN    = 4'd5;
    localparam logic [IDX_W-1:0] W_STRIDE = 4'd6;
    localparam logic [IDX_W-1:0] W_NEXT   = 4'd7;
    localparam logic [IDX_W-1:0] W_ERR    = 4'd8;
    localparam int               W_LAST   = 8;

    // control/status bit positions
    localparam int B_ACTIVE  = 0;
    localparam int B_END     = 1;
    localparam int B_INT     = 2;
    localparam int B_DREQ    = 3;
    localparam int B_PAUSED  = 4;
    localparam int B_HELD    = 5;
    localparam int B_WAITING = 6;
    localparam int B_ERROR   = 8;
    localparam int B_WFW     = 28;
    localparam int B_NODBG   = 29;
    localparam int B_ABORT   = 30;
    localparam int B_RESET   = 31;

    // sequencer load field codes
    typedef enum logic [2:0] {
        LD_INFO   = 3'd0,
        LD_SRC    = 3'd1,
        LD_DST    = 3'd2,
        LD_LEN    = 3'd3,
        LD_STRIDE = 3'd4,
        LD_NEXT   = 3'd5
    } ld_field_e;

    typedef struct packed {
        logic              active;
        logic              end_f;
        logic              int_f;
        logic              wfw;
        logic              nodbg;
        logic              go;
        logic              abort;
        logic [ERR_W-1:0]  err;
        logic [DATA_W-1:0] cb_addr;
        logic [DATA_W-1:0] nxt;
        logic [DATA_W-1:0] info;
        logic [DATA_W-1:0] src;
        logic [DATA_W-1:0] dst;
        logic [DATA_W-1:0] len;
        logic [DATA_W-1:0] stride;
    } chan_state_t;
endpackage

// File: rtl/dma_csr_chan.sv
module dma_csr_chan
    import dma_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic [IDX_W-1:0]  word_idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_word,
    input  logic              chan_en,
    input  logic              ld_sel,
    input  logic [2:0]        ld_field,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              sq_paused,
    input  logic              sq_held,
    input  logic              sq_waiting,
    input  logic              sq_dreq,
    input  logic              sq_done,
    input  logic [ERR_W-1:0]  sq_err_set,
    output logic              run,
    output logic              go,
    output logic              abort,
    output logic [DATA_W-1:0] desc_addr,
    output logic              irq
);
    chan_state_t s_d, s_q;
    logic        cs_wr;
    logic        reset_cmd;
    ld_field_e   fld;

    assign cs_wr     = wr_sel && (word_idx == W_CS);
    assign reset_cmd = cs_wr && wdata[B_RESET];
    assign fld       = ld_field_e'(ld_field);

    always_comb begin
        s_d       = s_q;
        s_d.go    = 1'b0;
        s_d.abort = 1'b0;

        // software side
        if (reset_cmd) begin
            s_d       = '0;
            s_d.abort = 1'b1;
        end else begin
            if (cs_wr) begin
                s_d.wfw   = wdata[B_WFW];
                s_d.nodbg = wdata[B_NODBG];
                if (wdata[B_END]) s_d.end_f = 1'b0;
                if (wdata[B_INT]) s_d.int_f = 1'b0;
                if (wdata[B_ABORT]) begin
                    s_d.abort = 1'b1;
                    if (s_q.active && (s_q.nxt != '0)) begin
                        s_d.cb_addr = s_q.nxt;
                        s_d.active  = 1'b1;
                        s_d.go      = 1'b1;
                    end else begin
                        s_d.active  = 1'b0;
                    end
                end else if (wdata[B_ACTIVE]) begin
                    if (!s_q.active && chan_en) begin
                        s_d.active = 1'b1;
                        s_d.go     = 1'b1;
                    end
                end else begin
                    s_d.active = 1'b0;
                end
            end
            if (wr_sel && (word_idx == W_DESC)) s_d.cb_addr = wdata;
            if (wr_sel && (word_idx == W_NEXT)) s_d.nxt     = wdata;
            if (wr_sel && (word_idx == W_ERR))  s_d.err     = s_q.err & ~wdata[ERR_W-1:0];

            // sequencer side, applied last so that a set wins over a clear
            if (ld_sel) begin
                case (fld)
                    LD_INFO:   s_d.info   = ld_data;
                    LD_SRC:    s_d.src    = ld_data;
                    LD_DST:    s_d.dst    = ld_data;
                    LD_LEN:    s_d.len    = ld_data;
                    LD_STRIDE: s_d.stride = ld_data;
                    LD_NEXT:   s_d.nxt    = ld_data;
                    default:   ;
                endcase
            end
            if (sq_done) begin
                s_d.end_f = 1'b1;
                if (s_q.info[0]) s_d.int_f = 1'b1;
                if (s_q.active) begin
                    if (s_q.nxt != '0) begin
                        s_d.cb_addr = s_q.nxt;
                        s_d.active  = 1'b1;
                        s_d.go      = 1'b1;
                    end else begin
                        s_d.active  = 1'b0;
                        s_d.go      = 1'b0;
                    end
                end
            end
            s_d.err = s_d.err | sq_err_set;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    logic [DATA_W-1:0] cs_word;
    always_comb begin
        cs_word            = '0;
        cs_word[B_ACTIVE]  = s_q.active;
        cs_word[B_END]     = s_q.end_f;
        cs_word[B_INT]     = s_q.int_f;
        cs_word[B_DREQ]    = sq_dreq;
        cs_word[B_PAUSED]  = sq_paused;
        cs_word[B_HELD]    = sq_held;
        cs_word[B_WAITING] = sq_waiting;
        cs_word[B_ERROR]   = |s_q.err;
        cs_word[B_WFW]     = s_q.wfw;
        cs_word[B_NODBG]   = s_q.nodbg;
    end

    always_comb begin
        case (word_idx)
            W_CS:     rd_word = cs_word;
            W_DESC:   rd_word = s_q.cb_addr;
            W_INFO:   rd_word = s_q.info;
            W_SRC:    rd_word = s_q.src;
            W_DST:    rd_word = s_q.dst;
            W_LEN:    rd_word = s_q.len;
            W_STRIDE: rd_word = s_q.stride;
            W_NEXT:   rd_word = s_q.nxt;
            W_ERR:    rd_word = {{(DATA_W-ERR_W){1'b0}}, s_q.err};
            default:  rd_word = '0;
        endcase
    end

    assign run       = s_q.active;
    assign go        = s_q.go;
    assign abort     = s_q.abort;
    assign desc_addr = s_q.cb_addr;
    assign irq       = s_q.int_f | (|s_q.err);
endmodule

// File: rtl/dma_csr_glob.sv
module dma_csr_glob
    import dma_csr_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_wr,
    input  logic [NUM_CH-1:0] en_wdata,
    input  logic              sel_irq,
    input  logic              sel_en,
    input  logic [NUM_CH-1:0] irq_vec,
    output logic [NUM_CH-1:0] en_mask,
    output logic [DATA_W-1:0] rd_word
);
    localparam int PAD_W = DATA_W - NUM_CH;

    logic [NUM_CH-1:0] en_d, en_q;

    always_comb begin
        en_d = en_q;
        if (en_wr) en_d = en_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    always_comb begin
        rd_word = '0;
        if (sel_irq)     rd_word = {{PAD_W{1'b0}}, irq_vec};
        else if (sel_en) rd_word = {{PAD_W{1'b0}}, en_q};
    end

    assign en_mask = en_q;
endmodule

// File: rtl/dma_chan_csr.sv
module dma_chan_csr
    import dma_csr_pkg::*;
#(
    parameter int  NUM_CH = 4,
    parameter int  ADDR_W = 12,
    localparam int WIN_W  = ADDR_W - 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_wr,
    input  logic                           bus_rd,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [DATA_W-1:0]              bus_wdata,
    output logic [DATA_W-1:0]              bus_rdata,
    input  logic                           ld_valid,
    input  logic [WIN_W-1:0]               ld_ch,
    input  logic [2:0]                     ld_field,
    input  logic [DATA_W-1:0]              ld_data,
    input  logic [NUM_CH-1:0]              sq_paused,
    input  logic [NUM_CH-1:0]              sq_held,
    input  logic [NUM_CH-1:0]              sq_waiting,
    input  logic [NUM_CH-1:0]              sq_dreq,
    input  logic [NUM_CH-1:0]              sq_done,
    input  logic [NUM_CH-1:0][ERR_W-1:0]   sq_err_set,
    output logic [NUM_CH-1:0]              ch_run,
    output logic [NUM_CH-1:0]              ch_go,
    output logic [NUM_CH-1:0]              ch_abort,
    output logic [NUM_CH-1:0][DATA_W-1:0]  ch_desc_addr,
    output logic [NUM_CH-1:0]              ch_irq
);
    localparam logic [WIN_W-1:0] GLOB_WIN = {WIN_W{1'b1}};
    localparam logic [7:0]       OFF_IRQ  = 8'hE0;
    localparam logic [7:0]       OFF_EN   = 8'hF0;

    logic [WIN_W-1:0]             win;
    logic [7:0]                   off;
    logic [IDX_W-1:0]             word_idx;
    logic                         word_ok;
    logic                         glob_hit;
    logic [NUM_CH-1:0]            en_mask;
    logic [DATA_W-1:0]            glob_rd;
    logic [NUM_CH-1:0][DATA_W-1:0] chan_rd;

    assign win      = bus_addr[ADDR_W-1:8];
    assign off      = bus_addr[7:0];
    assign word_idx = off[5:2];
    assign word_ok  = (off[7:6] == 2'b00) && (off[1:0] == 2'b00) &&
                      (int'(word_idx) <= W_LAST);
    assign glob_hit = (win == GLOB_WIN);

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            logic sel_here;
            assign sel_here = (win == i[WIN_W-1:0]) && word_ok;

            dma_csr_chan u_chan (
                .clk        (clk),
                .rst_n      (rst_n),
                .wr_sel     (bus_wr && sel_here),
                .word_idx   (word_idx),
                .wdata      (bus_wdata),
                .rd_word    (chan_rd[i]),
                .chan_en    (en_mask[i]),
                .ld_sel     (ld_valid && (ld_ch == i[WIN_W-1:0])),
                .ld_field   (ld_field),
                .ld_data    (ld_data),
                .sq_paused  (sq_paused[i]),
                .sq_held    (sq_held[i]),
                .sq_waiting (sq_waiting[i]),
                .sq_dreq    (sq_dreq[i]),
                .sq_done    (sq_done[i]),
                .sq_err_set (sq_err_set[i]),
                .run        (ch_run[i]),
                .go         (ch_go[i]),
                .abort      (ch_abort[i]),
                .desc_addr  (ch_desc_addr[i]),
                .irq        (ch_irq[i])
            );
        end
    endgenerate

    dma_csr_glob #(.NUM_CH(NUM_CH)) u_glob (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_wr    (bus_wr && glob_hit && (off == OFF_EN)),
        .en_wdata (bus_wdata[NUM_CH-1:0]),
        .sel_irq  (glob_hit && (off == OFF_IRQ)),
        .sel_en   (glob_hit && (off == OFF_EN)),
        .irq_vec  (ch_irq),
        .en_mask  (en_mask),
        .rd_word  (glob_rd)
    );

    logic [DATA_W-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = '0;
        if (bus_rd) begin
            if (glob_hit) begin
                rdata_d = glob_rd;
            end else if (word_ok) begin
                for (int i = 0; i < NUM_CH; i++) begin
                    if (win == i[WIN_W-1:0]) rdata_d = chan_rd[i];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/dma_chan_csr_chk.sv
module dma_chan_csr_chk #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [31:0]       bus_rdata,
    input logic [NUM_CH-1:0] ch_run,
    input logic [NUM_CH-1:0] ch_go,
    input logic [NUM_CH-1:0] ch_irq,
    input logic [NUM_CH-1:0] en_mask
);
    // R13: data only in the cycle after a read strobe
    a_r13_rdata_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_rd) |-> (bus_rdata == 32'h0));

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
            // R2: a start pulse comes with the run level
            a_r2_go_runs: assert property (@(posedge clk) disable iff (!rst_n)
                ch_go[i] |-> ch_run[i]);
            // R3: a channel only starts running while enabled
            a_r3_rise_enabled: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(ch_run[i]) |-> $past(en_mask[i]));
            // R5: an interrupt only goes away through a register write
            a_r5_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
                (ch_irq[i] && !bus_wr) |=> ch_irq[i]);
        end
    endgenerate
endmodule

bind dma_chan_csr dma_chan_csr_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .ch_run    (ch_run),
    .ch_go     (ch_go),
    .ch_irq    (ch_irq),
    .en_mask   (en_mask)
);

// File: tb/dma_chan_csr_tb_top.sv
module dma_chan_csr_tb_top;
    localparam int NCH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic                  bus_wr = 0, bus_rd = 0;
    logic [11:0]           bus_addr = '0;
    logic [31:0]           bus_wdata = '0;
    logic [31:0]           bus_rdata;
    logic                  ld_valid = 0;
    logic [3:0]            ld_ch = '0;
    logic [2:0]            ld_field = '0;
    logic [31:0]           ld_data = '0;
    logic [NCH-1:0]        sq_paused = '0, sq_held = '0, sq_waiting = '0, sq_dreq = '0, sq_done = '0;
    logic [NCH-1:0][2:0]   sq_err_set = '0;
    logic [NCH-1:0]        ch_run, ch_go, ch_abort, ch_irq;
    logic [NCH-1:0][31:0]  ch_desc_addr;

    dma_chan_csr #(.NUM_CH(NCH), .ADDR_W(12)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ld_valid(ld_valid), .ld_ch(ld_ch), .ld_field(ld_field), .ld_data(ld_data),
        .sq_paused(sq_paused), .sq_held(sq_held), .sq_waiting(sq_waiting),
        .sq_dreq(sq_dreq), .sq_done(sq_done), .sq_err_set(sq_err_set),
        .ch_run(ch_run), .ch_go(ch_go), .ch_abort(ch_abort),
        .ch_desc_addr(ch_desc_addr), .ch_irq(ch_irq)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1; bus_addr = a;
        @(negedge clk);
        bus_rd = 0;
        d = bus_rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(tag, d, exp);
    endtask

    task automatic load(input int ch, input logic [2:0] f, input logic [31:0] d);
        @(negedge clk);
        ld_valid = 1; ld_ch = ch[3:0]; ld_field = f; ld_data = d;
        @(negedge clk);
        ld_valid = 0;
    endtask

    task automatic done_pulse(input int ch);
        @(negedge clk);
        sq_done[ch] = 1;
        @(negedge clk);
        sq_done[ch] = 0;
    endtask

    // {is_write, addr, data, expected}
    localparam logic [76:0] VEC [12] = '{
        {1'b1, 12'h004, 32'h1000_0020, 32'h0},
        {1'b0, 12'h004, 32'h0,         32'h1000_0020},
        {1'b1, 12'h11C, 32'h0000_0040, 32'h0},
        {1'b0, 12'h11C, 32'h0,         32'h0000_0040},
        {1'b1, 12'h108, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 12'h108, 32'h0,         32'h0},
        {1'b1, 12'hFF0, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 12'hFF0, 32'h0,         32'h0000_000F},
        {1'b0, 12'h404, 32'h0,         32'h0},
        {1'b0, 12'h024, 32'h0,         32'h0},
        {1'b1, 12'hFE0, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 12'hFE0, 32'h0,         32'h0}
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual %h expected %h", 32'h1, 32'h0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // reset state
        rd_chk("R1 reset cs", 12'h000, 32'h0);
        check("R5 reset irq", {28'h0, ch_irq}, 32'h0);
        check("R2 reset run", {28'h0, ch_run}, 32'h0);

        // vector table: R1 R10 R11 R13
        for (int i = 0; i < 12; i++) begin
            if (VEC[i][76]) wr(VEC[i][75:64], VEC[i][63:32]);
            else rd_chk($sformatf("R1 R10 R11 R13 vector %0d", i), VEC[i][75:64], VEC[i][31:0]);
        end

        // R13: idle read data
        @(negedge clk);
        check("R13 idle rdata", bus_rdata, 32'h0);

        // R2: start
        wr(12'h000, 32'h1);
        check("R2 go pulse", {31'h0, ch_go[0]}, 32'h1);
        check("R2 run", {31'h0, ch_run[0]}, 32'h1);
        check("R2 desc addr", ch_desc_addr[0], 32'h1000_0020);
        rd_chk("R2 cs active", 12'h000, 32'h1);

        // R4: pause and live status
        wr(12'h000, 32'h0);
        check("R4 run low", {31'h0, ch_run[0]}, 32'h0);
        sq_paused[0] = 1; sq_dreq[0] = 1;
        rd_chk("R4 paused+dreq", 12'h000, 32'h18);
        sq_paused[0] = 0; sq_dreq[0] = 0; sq_held[0] = 1; sq_waiting[0] = 1;
        rd_chk("R4 held+waiting", 12'h000, 32'h60);
        sq_held[0] = 0; sq_waiting[0] = 0;
        wr(12'h000, 32'h1);
        check("R4 resume go", {31'h0, ch_go[0]}, 32'h1);

        // R10: loaded fields read-only
        load(0, 3'd0, 32'h1);
        load(0, 3'd1, 32'hAAAA_0000);
        load(0, 3'd3, 32'h0000_0100);
        rd_chk("R10 info", 12'h008, 32'h1);
        rd_chk("R10 src", 12'h00C, 32'hAAAA_0000);
        wr(12'h014, 32'h0);
        rd_chk("R10 len ignores write", 12'h014, 32'h0000_0100);

        // R6 / R5: chained completion
        wr(12'h01C, 32'h200);
        done_pulse(0);
        check("R6 chain desc", ch_desc_addr[0], 32'h200);
        check("R6 chain go", {31'h0, ch_go[0]}, 32'h1);
        rd_chk("R5 end+int set", 12'h000, 32'h7);
        check("R5 irq", {31'h0, ch_irq[0]}, 32'h1);
        rd_chk("R11 int status", 12'hFE0, 32'h1);
        wr(12'h01C, 32'h0);
        done_pulse(0);
        check("R6 stop run", {31'h0, ch_run[0]}, 32'h0);
        check("R6 stop no go", {31'h0, ch_go[0]}, 32'h0);
        rd_chk("R6 stop cs", 12'h000, 32'h6);
        wr(12'h000, 32'h2);
        rd_chk("R5 clear end only", 12'h000, 32'h4);
        check("R5 irq still", {31'h0, ch_irq[0]}, 32'h1);
        wr(12'h000, 32'h4);
        rd_chk("R5 clear int", 12'h000, 32'h0);
        check("R5 irq low", {31'h0, ch_irq[0]}, 32'h0);

        // R12: completion and clear in one cycle
        wr(12'h000, 32'h1);
        @(negedge clk);
        bus_wr = 1; bus_addr = 12'h000; bus_wdata = 32'h7; sq_done[0] = 1;
        @(negedge clk);
        bus_wr = 0; sq_done[0] = 0;
        rd_chk("R12 set wins", 12'h000, 32'h6);
        wr(12'h000, 32'h6);

        // R7: abort
        wr(12'h01C, 32'h300);
        wr(12'h000, 32'h1);
        wr(12'h000, 32'h4000_0001);
        check("R7 abort pulse", {31'h0, ch_abort[0]}, 32'h1);
        check("R7 jump go", {31'h0, ch_go[0]}, 32'h1);
        check("R7 jump desc", ch_desc_addr[0], 32'h300);
        wr(12'h01C, 32'h0);
        wr(12'h000, 32'h4000_0001);
        check("R7 abort pulse 2", {31'h0, ch_abort[0]}, 32'h1);
        check("R7 stop run", {31'h0, ch_run[0]}, 32'h0);
        check("R7 stop no go", {31'h0, ch_go[0]}, 32'h0);
        rd_chk("R7 cs", 12'h000, 32'h0);

        // R8: error code
        @(negedge clk);
        sq_err_set[1] = 3'b101;
        @(negedge clk);
        sq_err_set[1] = 3'b000;
        rd_chk("R8 code", 12'h120, 32'h5);
        rd_chk("R8 error bit", 12'h100, 32'h100);
        check("R8 irq", {31'h0, ch_irq[1]}, 32'h1);
        rd_chk("R11 int status ch1", 12'hFE0, 32'h2);
        wr(12'h120, 32'h1);
        rd_chk("R8 partial clear", 12'h120, 32'h4);
        wr(12'h120, 32'h4);
        rd_chk("R8 cleared", 12'h100, 32'h0);
        check("R8 irq low", {31'h0, ch_irq[1]}, 32'h0);

        // R3: masked start
        wr(12'hFF0, 32'hD);
        wr(12'h100, 32'h1);
        check("R3 no run", {31'h0, ch_run[1]}, 32'h0);
        check("R3 no go", {31'h0, ch_go[1]}, 32'h0);
        rd_chk("R3 cs", 12'h100, 32'h0);
        wr(12'hFF0, 32'hF);

        // R9: channel reset
        wr(12'h204, 32'h40);
        wr(12'h21C, 32'h80);
        load(2, 3'd0, 32'h5);
        wr(12'h304, 32'h99);
        wr(12'h200, 32'h3000_0001);
        rd_chk("R9 cs before", 12'h200, 32'h3000_0001);
        wr(12'h200, 32'h8000_0000);
        check("R9 abort pulse", {31'h0, ch_abort[2]}, 32'h1);
        check("R9 run low", {31'h0, ch_run[2]}, 32'h0);
        rd_chk("R9 cs", 12'h200, 32'h0);
        rd_chk("R9 desc", 12'h204, 32'h0);
        rd_chk("R9 next", 12'h21C, 32'h0);
        rd_chk("R9 info", 12'h208, 32'h0);
        rd_chk("R9 neighbour", 12'h304, 32'h99);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule